// File: doc/BRIEF.md
# SD/MMC Command and Response Engine

This block is the command-line half of an SD/MMC host controller. Software loads a 6-bit command index and a 32-bit argument into their registers, then writes the control register with a transfer-mode code and the start bit. The engine builds the 48-bit command frame, appends its CRC7, and shifts it out on the CMD line most significant bit first, one bit per cycle. Depending on the mode, it then waits for and captures a 48-bit or 136-bit response, optionally waits for the card to release DAT0, or only runs idle bus clocks for card start-up.

Each transfer ends by clearing the start bit and setting a completion flag. Software clears that flag by writing one to it. An interrupt line is high while the completion flag and its enable are both set. A missing response and a CRC7 mismatch are reported as separate status bits. Data-line transfers are not carried out here. The read-block and write-block modes run only their command phase and then complete.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset the control register reads 0, the status register reads only the CMD line level in bit 11, and `irq` is low.
- R2: A started command is driven on `cmdOut` with `cmdOe` high for exactly 48 consecutive cycles, MSB first. The frame is start bit 0, direction bit 1, 6-bit index, 32-bit argument, CRC7 with polynomial x^7+x^3+1 computed over the preceding 40 bits, and end bit 1.
- R3: Mode code 0 sends the command, expects no response, and completes with both error bits clear.
- R4: Mode code 1 captures a 48-bit response. Response word 0 (word address 5) holds frame bits 31:0: status bits 23:0 in bits 31:8, then CRC7 and the end bit. Response word 1 (word address 6) holds frame bits 47:32: status bits 31:24 in bits 7:0 and {start, direction, index} in bits 15:8.
- R5: A 48-bit response whose CRC7 does not match sets status bit 0.
- R6: Mode code 2 captures a 136-bit response. Its last 128 bits go to response words 0 to 3, with the least significant 32 bits in word 0. No CRC7 check is made, so status bit 0 stays clear.
- R7: If no response start bit (CMD low) arrives within 64 cycles after the command, status bit 4 is set and the transfer completes.
- R8: Mode code 3 captures a 48-bit response, then holds off completion while `dat0In` is low.
- R9: Mode code 8 sends no command and keeps `busClkEn` high for 16 times the clock-count field (control bits 11:8).
- R10: Status bit 5 is set on completion and cleared by writing 1 to it. `irq` equals status bit 5 AND status bit 6.
- R11: Control bit 7 (start) clears itself when the transfer completes. A start written while the enable bit (word 0 bit 0) is 0 is dropped.
- R12: Mode codes 4 and 5 run the same command and 48-bit response phase as mode 1 and then complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one CMD bit per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Word address: 0 enable, 1 control, 2 status, 3 index, 4 argument, 5-8 response words 0-3 |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| cmdIn | input | 1 | CMD line level from the card |
| dat0In | input | 1 | DAT0 level, low while the card is busy |
| cmdOut | output | 1 | CMD line drive value |
| cmdOe | output | 1 | CMD line output enable |
| busClkEn | output | 1 | High while the bus clock should run |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The engine is run with a CMD0 frame whose CRC is known, so the frame and its CRC logic are checked against a fixed value. A short response with a correct CRC is compared with the same response carrying a flipped CRC bit, which isolates the error flag from the capture path. A long response with arbitrary internal bits shows that the long mode skips the check and fills all four words. A silent card shows the timeout path. A card that holds DAT0 low shows that completion waits for busy. An init run with clock count 5 shows that no frame is sent and gives an exact clock count. The read and write mode codes must give the same result as mode 1.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam logic [3:0] MODE_NONE       = 4'd0;
  localparam logic [3:0] MODE_SHORT      = 4'd1;
  localparam logic [3:0] MODE_LONG       = 4'd2;
  localparam logic [3:0] MODE_SHORT_BUSY = 4'd3;
  localparam logic [3:0] MODE_READ       = 4'd4;
  localparam logic [3:0] MODE_WRITE      = 4'd5;
  localparam logic [3:0] MODE_INIT       = 4'd8;

  typedef enum logic [2:0] {
    S_IDLE, S_TX, S_WAIT, S_RX, S_BUSY, S_CLKS
  } engState_t;

  typedef struct packed {
    logic shiftTx;
    logic shiftRx;
    logic capture;
    logic setNoResp;
    logic finish;
  } strobe_t;

  function automatic logic [6:0] crc7(input logic [39:0] bits);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = bits[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int CmdLen      = 48,
  parameter int ShortLen    = 48,
  parameter int LongLen     = 136,
  parameter int NoRespLimit = 64,
  parameter int IdleMult    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [3:0] mode,
  input  logic [3:0] clkCnt,
  input  logic       cmdIn,
  input  logic       dat0In,
  output strobe_t    strb,
  output logic       engaged,
  output logic       cmdOe,
  output logic       busClkEn
);
  localparam int CntW = $clog2(IdleMult * 16 + LongLen);

  engState_t       state;
  logic [CntW-1:0] cnt;

  logic wantShort, wantLong, wantResp, wantBusy, isInit;
  logic [CntW-1:0] rxLoad, idleLoad;

  always_comb begin
    wantShort = (mode == MODE_SHORT) || (mode == MODE_SHORT_BUSY) ||
                (mode == MODE_READ)  || (mode == MODE_WRITE);
    wantLong  = (mode == MODE_LONG);
    wantResp  = wantShort || wantLong;
    wantBusy  = (mode == MODE_SHORT_BUSY);
    isInit    = (mode == MODE_INIT);
    rxLoad    = wantLong ? CntW'(LongLen - 2) : CntW'(ShortLen - 2);
    idleLoad  = CntW'(IdleMult) * CntW'(clkCnt);
  end

  always_comb begin
    strb = '0;
    unique case (state)
      S_IDLE: if (startReq && isInit && clkCnt == 4'd0) strb.finish = 1'b1;
      S_TX: begin
        strb.shiftTx = 1'b1;
        if (cnt == '0 && !wantResp) strb.finish = 1'b1;
      end
      S_WAIT: begin
        if (!cmdIn) strb.shiftRx = 1'b1;
        else if (cnt == CntW'(NoRespLimit - 1)) begin
          strb.setNoResp = 1'b1;
          strb.finish    = 1'b1;
        end
      end
      S_RX: begin
        strb.shiftRx = 1'b1;
        if (cnt == '0) begin
          strb.capture = 1'b1;
          if (!wantBusy) strb.finish = 1'b1;
        end
      end
      S_BUSY: if (dat0In) strb.finish = 1'b1;
      S_CLKS: if (cnt == CntW'(1)) strb.finish = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (startReq) begin
          if (isInit) begin
            if (clkCnt != 4'd0) begin
              state <= S_CLKS;
              cnt   <= idleLoad;
            end
          end else begin
            state <= S_TX;
            cnt   <= CntW'(CmdLen - 1);
          end
        end
        S_TX: begin
          if (cnt == '0) begin
            state <= wantResp ? S_WAIT : S_IDLE;
            cnt   <= '0;
          end else cnt <= cnt - 1'b1;
        end
        S_WAIT: begin
          if (!cmdIn) begin
            state <= S_RX;
            cnt   <= rxLoad;
          end else if (cnt == CntW'(NoRespLimit - 1)) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        S_RX: begin
          if (cnt == '0) state <= wantBusy ? S_BUSY : S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_BUSY: if (dat0In) state <= S_IDLE;
        S_CLKS: begin
          if (cnt == CntW'(1)) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign engaged  = (state != S_IDLE);
  assign cmdOe    = (state == S_TX);
  assign busClkEn = (state != S_IDLE);

  // R7: the response wait never runs past its window
  a_r7_wait_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> (cnt < CntW'(NoRespLimit)));

  // R2: the transmit counter stays inside one frame
  a_r2_tx_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX) |-> (cnt < CntW'(CmdLen)));

  // R8: no completion while the card holds DAT0 low
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && !dat0In) |-> !strb.finish);

endmodule

// File: rtl/sdcmd_dp.sv
module sdcmd_dp
  import sdcmd_pkg::*;
#(
  parameter int CmdLen   = 48,
  parameter int RspWords = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        regWr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  strobe_t     strb,
  input  logic        engaged,
  input  logic        cmdIn,
  output logic        cmdOut,
  output logic        startReq,
  output logic [3:0]  mode,
  output logic [3:0]  clkCnt,
  output logic        irq
);
  localparam int RspBits = RspWords * 32;
  localparam logic [3:0] A_EN = 4'd0, A_CTL = 4'd1, A_STAT = 4'd2,
                         A_IDX = 4'd3, A_ARG = 4'd4, A_RSP = 4'd5;

  logic              enBit, startBit, toutEn;
  logic [6:0]        toutCnt;
  logic              crcErr, noResp, endPend, endIe;
  logic [5:0]        cmdIdx;
  logic [31:0]       cmdArg;
  logic [31:0]       rsp [RspWords];
  logic [CmdLen-1:0] txSh;
  logic [RspBits-2:0] rxSh;
  logic [RspBits-1:0] rxNext;
  logic [39:0]       txBody;
  logic              ctlWr;

  assign txBody = {1'b0, 1'b1, cmdIdx, cmdArg};
  assign rxNext = {rxSh, cmdIn};
  assign ctlWr  = regWr && regAddr == A_CTL && !engaged && !startBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit <= 1'b0; startBit <= 1'b0; toutEn <= 1'b0; toutCnt <= '0;
      mode <= '0; clkCnt <= '0;
      crcErr <= 1'b0; noResp <= 1'b0; endPend <= 1'b0; endIe <= 1'b0;
      cmdIdx <= '0; cmdArg <= '0; txSh <= '0; rxSh <= '0;
      for (int w = 0; w < RspWords; w++) rsp[w] <= '0;
    end else begin
      if (regWr && regAddr == A_EN)  enBit  <= regWdata[0];
      if (regWr && regAddr == A_IDX) cmdIdx <= regWdata[5:0];
      if (regWr && regAddr == A_ARG) cmdArg <= regWdata;
      if (ctlWr) begin
        toutEn   <= regWdata[31];
        toutCnt  <= regWdata[30:24];
        clkCnt   <= regWdata[11:8];
        mode     <= regWdata[3:0];
        startBit <= regWdata[7] && enBit;
        if (regWdata[7] && enBit) begin
          crcErr <= 1'b0;
          noResp <= 1'b0;
          txSh   <= {txBody, crc7(txBody), 1'b1};
        end
      end
      if (regWr && regAddr == A_STAT) begin
        endIe <= regWdata[6];
        if (regWdata[5]) endPend <= 1'b0;
      end
      if (strb.shiftTx) txSh <= {txSh[CmdLen-2:0], 1'b0};
      if (strb.shiftRx) rxSh <= rxNext[RspBits-2:0];
      if (strb.capture) begin
        if (mode == MODE_LONG) begin
          for (int w = 0; w < RspWords; w++) rsp[w] <= rxNext[w*32 +: 32];
          crcErr <= 1'b0;
        end else begin
          rsp[0] <= rxNext[31:0];
          rsp[1] <= {16'h0, rxNext[47:32]};
          crcErr <= (rxNext[7:1] != crc7(rxNext[47:8]));
        end
      end
      if (strb.setNoResp) noResp <= 1'b1;
      if (strb.finish) begin
        startBit <= 1'b0;
        endPend  <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_EN:   regRdata = {31'h0, enBit};
      A_CTL:  regRdata = {toutEn, toutCnt, 12'h0, clkCnt, startBit, 3'h0, mode};
      A_STAT: regRdata = {20'h0, cmdIn, 4'h0, endIe, endPend, noResp, 3'h0, crcErr};
      A_IDX:  regRdata = {26'h0, cmdIdx};
      A_ARG:  regRdata = cmdArg;
      default: begin
        for (int w = 0; w < RspWords; w++)
          if (regAddr == A_RSP + 4'(w)) regRdata = rsp[w];
      end
    endcase
  end

  assign cmdOut   = txSh[CmdLen-1];
  assign startReq = startBit;
  assign irq      = endPend && endIe;

  // R11: completion flag only rises together with the start bit clearing
  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endPend) |-> !startBit);

  // R5: the CRC error flag only rises on a response capture
  a_r5_crc_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcErr) |-> $past(strb.capture));

  // R10: writing one to the pending bit clears it unless a completion collides
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == A_STAT && regWdata[5] && !strb.finish) |=> !endPend);

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int CmdLen      = 48,
  parameter int LongLen     = 136,
  parameter int NoRespLimit = 64,
  parameter int IdleMult    = 16,
  parameter int RspWords    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        regWr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        cmdIn,
  input  logic        dat0In,
  output logic        cmdOut,
  output logic        cmdOe,
  output logic        busClkEn,
  output logic        irq
);
  strobe_t    strb;
  logic       engaged, startReq;
  logic [3:0] mode, clkCnt;

  sdcmd_ctrl #(
    .CmdLen(CmdLen), .ShortLen(CmdLen), .LongLen(LongLen),
    .NoRespLimit(NoRespLimit), .IdleMult(IdleMult)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .mode(mode), .clkCnt(clkCnt),
    .cmdIn(cmdIn), .dat0In(dat0In), .strb(strb), .engaged(engaged),
    .cmdOe(cmdOe), .busClkEn(busClkEn)
  );

  sdcmd_dp #(.CmdLen(CmdLen), .RspWords(RspWords)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb), .engaged(engaged),
    .cmdIn(cmdIn), .cmdOut(cmdOut), .startReq(startReq), .mode(mode),
    .clkCnt(clkCnt), .irq(irq)
  );

endmodule

// File: tb/sdcmd_engine_bench.sv
`timescale 1ns/1ps
module sdcmd_engine_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic cmdIn = 1'b1, dat0In = 1'b1;
  logic cmdOut, cmdOe, busClkEn, irq;

  always #2.5 clk = ~clk;

  sdcmd_engine u_sdcmd_engine (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .cmdIn(cmdIn), .dat0In(dat0In),
    .cmdOut(cmdOut), .cmdOe(cmdOe), .busClkEn(busClkEn), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [47:0] expQ[$];
  int cardResp = 0;          // 0 silent, 48 or 136 = response length
  logic [135:0] rspFrame = '0;
  int busyLen = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] refCrc(input logic [39:0] m);
    logic [6:0] r = '0;
    for (int i = 39; i >= 0; i--)
      r = {r[5:0], 1'b0} ^ ((m[i] ^ r[6]) ? 7'b0001001 : 7'b0);
    return r;
  endfunction

  function automatic logic [47:0] cmdFrame(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, refCrc({2'b01, idx, arg}), 1'b1};
  endfunction

  function automatic logic [47:0] shortRsp(input logic [5:0] idx, input logic [31:0] st,
                                           input bit bad);
    logic [6:0] c = refCrc({2'b00, idx, st}) ^ (bad ? 7'h01 : 7'h00);
    return {2'b00, idx, st, c, 1'b1};
  endfunction

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #0.5; d = regRdata;
  endtask

  // driver: pushes the expected frame, then starts the transfer
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                       input logic [3:0] md, input logic [3:0] cc);
    if (md != 4'd8) expQ.push_back(cmdFrame(idx, arg));
    regWrite(4'd3, {26'h0, idx});
    regWrite(4'd4, arg);
    regWrite(4'd1, {20'h0, cc, 1'b1, 3'b0, md});
  endtask

  task automatic waitEnd(input string req);
    logic [31:0] s = '0;
    for (int i = 0; i < 3000 && !s[5]; i++) regRead(4'd2, s);
    chk(s[5], req, {127'h0, s[5]}, 128'h1);
  endtask

  // monitor and card model: captures frames, compares, answers
  initial begin
    logic [47:0] got;
    logic [47:0] exp;
    forever begin
      @(negedge clk);
      if (cmdOe) begin
        got[47] = cmdOut;
        for (int i = 46; i >= 0; i--) begin @(negedge clk); got[i] = cmdOut; end
        @(negedge clk);
        chk(!cmdOe, "R2 frame length", {127'h0, cmdOe}, 128'h0);
        if (expQ.size() == 0) chk(1'b0, "R2 unexpected frame", {80'h0, got}, 128'h0);
        else begin
          exp = expQ.pop_front();
          chk(got == exp, "R2 command frame", {80'h0, got}, {80'h0, exp});
        end
        if (cardResp != 0) begin
          repeat (2) @(negedge clk);
          for (int i = cardResp - 1; i >= 0; i--) begin
            cmdIn = rspFrame[i]; @(negedge clk);
          end
          cmdIn = 1'b1;
          if (busyLen > 0) begin
            dat0In = 1'b0;
            repeat (busyLen) @(negedge clk);
            dat0In = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog (all requirements): actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [47:0] f;
    logic [127:0] pay;
    int n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(4'd1, r); chk(r == 0, "R1 control reset", {96'h0, r}, 128'h0);
    regRead(4'd2, r); chk(r == 32'h800, "R1 status reset", {96'h0, r}, 128'h800);
    chk(irq == 0, "R1 irq reset", {127'h0, irq}, 128'h0);

    // R11 start dropped while disabled
    regWrite(4'd1, 32'h80);
    regRead(4'd1, r); chk(r[7] == 0, "R11 start while disabled", {96'h0, r}, 128'h0);
    repeat (80) @(negedge clk);
    regRead(4'd2, r); chk(r[5] == 0, "R11 no completion while disabled", {96'h0, r}, 128'h800);

    regWrite(4'd0, 32'h1);
    regWrite(4'd2, 32'h40);

    // R2 / R3 CMD0, mode 0
    chk(refCrc(40'h4000000000) == 7'h4A, "R2 CRC7 of CMD0", {121'h0, refCrc(40'h4000000000)}, 128'h4A);
    cardResp = 0;
    issue(6'd0, 32'h0, 4'd0, 4'd0);
    waitEnd("R3 mode 0 completes");
    regRead(4'd2, r);
    chk(r[0] == 0 && r[4] == 0, "R3 no errors", {96'h0, r}, 128'h860);
    chk(irq == 1, "R10 irq with enable", {127'h0, irq}, 128'h1);
    regRead(4'd1, r); chk(r[7] == 0, "R11 start self-clears", {96'h0, r}, 128'h0);

    // R10 write-one-to-clear
    regWrite(4'd2, 32'h60);
    regRead(4'd2, r); chk(r[5] == 0, "R10 W1C", {96'h0, r}, 128'h840);
    chk(irq == 0, "R10 irq drops", {127'h0, irq}, 128'h0);

    // R4 short response
    f = shortRsp(6'd17, 32'h12345678, 0);
    rspFrame = {88'h0, f}; cardResp = 48;
    issue(6'd17, 32'hABCD0001, 4'd1, 4'd0);
    waitEnd("R4 completes");
    regRead(4'd5, r);
    chk(r == {24'h345678, refCrc({2'b00, 6'd17, 32'h12345678}), 1'b1}, "R4 resp word0",
        {96'h0, r}, {96'h0, 24'h345678, refCrc({2'b00, 6'd17, 32'h12345678}), 1'b1});
    regRead(4'd6, r);
    chk(r == {16'h0, 2'b00, 6'd17, 8'h12}, "R4 resp word1", {96'h0, r}, {112'h0, 8'h11, 8'h12});
    regRead(4'd2, r); chk(r[0] == 0 && r[4] == 0, "R4 no errors", {96'h0, r}, 128'h860);
    regWrite(4'd2, 32'h60);

    // R5 bad CRC
    rspFrame = {88'h0, shortRsp(6'd13, 32'h00000900, 1)};
    issue(6'd13, 32'h00010000, 4'd1, 4'd0);
    waitEnd("R5 completes");
    regRead(4'd2, r); chk(r[0] == 1, "R5 CRC error flag", {96'h0, r}, 128'h861);
    regWrite(4'd2, 32'h60);

    // R6 long response, internal CRC not checked
    pay = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'h5555AAA1};
    rspFrame = {8'h3F, pay}; cardResp = 136;
    issue(6'd2, 32'h0, 4'd2, 4'd0);
    waitEnd("R6 completes");
    for (int w = 0; w < 4; w++) begin
      regRead(4'(5 + w), r);
      chk(r == pay[w*32 +: 32], "R6 long word", {96'h0, r}, {96'h0, pay[w*32 +: 32]});
    end
    regRead(4'd2, r); chk(r[0] == 0, "R6 CRC not checked", {96'h0, r}, 128'h860);
    regWrite(4'd2, 32'h60);

    // R7 no response
    cardResp = 0;
    issue(6'd8, 32'h1AA, 4'd1, 4'd0);
    waitEnd("R7 completes");
    regRead(4'd2, r); chk(r[4] == 1 && r[0] == 0, "R7 no-response flag", {96'h0, r}, 128'h870);
    regWrite(4'd2, 32'h60);

    // R8 busy wait
    rspFrame = {88'h0, shortRsp(6'd7, 32'h00000700, 0)}; cardResp = 48; busyLen = 20;
    issue(6'd7, 32'h00050000, 4'd3, 4'd0);
    @(negedge dat0In);
    repeat (5) @(negedge clk);
    regRead(4'd2, r); chk(r[5] == 0, "R8 held during busy", {96'h0, r}, 128'h840);
    waitEnd("R8 completes after busy");
    busyLen = 0;
    regWrite(4'd2, 32'h60);

    // R9 init clocks
    cardResp = 0; n = 0;
    issue(6'd0, 32'h0, 4'd8, 4'd5);
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (busClkEn) n++; end
    chk(n == 80, "R9 idle clock count", 128'(n), 128'd80);
    regRead(4'd2, r); chk(r[5] == 1, "R9 completes", {96'h0, r}, 128'h860);
    regWrite(4'd2, 32'h60);

    // R12 read/write modes
    cardResp = 48;
    for (int m = 4; m <= 5; m++) begin
      rspFrame = {88'h0, shortRsp(6'd18, 32'hA5A50000 + 32'(m), 0)};
      issue(6'd18, 32'h200, 4'(m), 4'd0);
      waitEnd("R12 completes");
      regRead(4'd6, r);
      chk(r == {16'h0, 8'h12, 8'hA5}, "R12 resp word1", {96'h0, r}, {112'h0, 16'h12A5});
      regRead(4'd2, r); chk(r[0] == 0 && r[4] == 0, "R12 no errors", {96'h0, r}, 128'h860);
      regWrite(4'd2, 32'h60);
    end

    // R10 pending without enable gives no irq
    regWrite(4'd2, 32'h0);
    cardResp = 0;
    issue(6'd0, 32'h0, 4'd0, 4'd0);
    waitEnd("R10 completes masked");
    chk(irq == 0, "R10 irq masked", {127'h0, irq}, 128'h0);

    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R2 all frames seen", 128'(expQ.size()), 128'h0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule